// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block holds a time-of-day value made of a seconds word and a sub-second word, and moves it forward on every cycle of its reference clock. Each advance adds a programmable sub-second step. The sub-second word wraps into the seconds word at one of two limits. In nanosecond mode the limit is one billion. In binary mode it is a power of two, so each count is a little under half a nanosecond.

Rate trimming uses an optional fractional accumulator. In trimmed mode the step is only added on cycles where a 32-bit accumulator, fed by an addend every cycle, overflows. Software trims the frequency by changing the addend. Software has three self-clearing commands. One loads a fresh time. One applies a signed offset to the running time. One moves a staged addend into the accumulator path. A snapshot strobe freezes both time words together, so that software can read a consistent pair.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, both time words, both snapshot words, all three busy flags and the active addend are zero.
- R2: With `fine_mode` low, every clock edge adds `sub_inc` to the sub-second word.
- R3: With `fine_mode` high, each edge adds the active addend to a 32-bit accumulator. `sub_inc` is applied only on edges where that addition carries out. With an addend of 0 the time does not advance. With an addend of 0x8000_0000 and the accumulator at zero, the step lands on every second edge, starting with the second.
- R4: With `digital_mode` high, a sub-second result of 1,000,000,000 or more has that limit removed and adds one to seconds.
- R5: With `digital_mode` low, the sub-second wrap limit is 2^31, with the same carry into seconds.
- R6: A `cmd_init` pulse raises `busy_init` after the edge that samples it. On the next edge, `upd_sec` and `upd_subsec[30:0]` become the time and `busy_init` returns low.
- R7: A `cmd_addend` pulse raises `busy_addend`. On the next edge, `addend_stage` becomes the active addend and the flag clears.
- R8: An offset update with flag `upd_subsec[31]` low adds `upd_sec` to seconds. It adds `upd_subsec[30:0]` to the sub-second word, and the sum carries into seconds at the active limit.
- R9: With `upd_subsec[31]` high, the offset is a subtraction. The seconds amount is supplied as 2^32 minus the amount, and the sub-second amount as the active limit minus the amount. The result borrows from seconds when needed, and the sub-second word always stays below the limit.
- R10: If init and offset update are pending together, init is applied first. The offset update stays pending and is applied on the following edge.
- R11: On an edge that applies init or an offset update, no sub-second step is added.
- R12: A `snap_req` edge copies the pre-edge seconds and sub-seconds together into `snap_sec` and `snap_subsec`. The copy holds until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fine_mode | input | 1 | 1: step gated by accumulator carry; 0: step every cycle |
| digital_mode | input | 1 | 1: sub-seconds wrap at 10^9; 0: wrap at 2^31 |
| sub_inc | input | 8 | Sub-second step |
| addend_stage | input | 32 | Staged addend |
| upd_sec | input | 32 | Seconds value for init or offset |
| upd_subsec | input | 32 | Bit 31 subtract flag, bits 30:0 sub-second value |
| cmd_init | input | 1 | Request a time load |
| cmd_update | input | 1 | Request an offset update |
| cmd_addend | input | 1 | Request an addend transfer |
| snap_req | input | 1 | Capture a coherent time snapshot |
| busy_init | output | 1 | Load pending |
| busy_update | output | 1 | Offset pending |
| busy_addend | output | 1 | Addend transfer pending |
| time_sec | output | 32 | Live seconds |
| time_subsec | output | 31 | Live sub-seconds |
| snap_sec | output | 32 | Snapshot seconds |
| snap_subsec | output | 31 | Snapshot sub-seconds |

## Verification
The bench uses the default parameters: 32-bit seconds, 31-bit sub-seconds, an 8-bit step, a 32-bit accumulator and a nanosecond limit of one billion. It reaches both wrap limits within a cycle or two by loading times just below them. It uses full-width two's-complement seconds encodings to cover subtraction with and without a borrow in both modes. An addend of one half makes the trimmed-rate carry pattern visible within a few edges.

// File: rtl/ptp_tc_pkg.sv
// Package ptp_tc_pkg: types shared by the time counter modules.
// Assumes: each command bit is handled independently by the sequencer.
package ptp_tc_pkg;

    // One bit per software command.
    typedef struct packed {
        logic init;
        logic update;
        logic addend;
    } ptp_cmd_t;

endpackage

// File: rtl/ptp_tc_cmd.sv
// ptp_tc_cmd: holds the self-clearing command flags and grants them.
// A request pulse sets its flag. The edge after that acts on it and clears it.
// Init outranks the offset update. A blocked update stays pending.
// Assumes: request pulses are synchronous to clk.
module ptp_tc_cmd
    import ptp_tc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ptp_cmd_t req,
    output ptp_cmd_t pend,
    output ptp_cmd_t go
);

    // Grant: init wins over update, addend is independent.
    always_comb begin
        go.init   = pend.init;
        go.update = pend.update & ~pend.init;
        go.addend = pend.addend;
    end

    // Pending flags: cleared when granted, set by a new request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend.init   <= (pend.init   & ~go.init)   | req.init;
            pend.update <= (pend.update & ~go.update) | req.update;
            pend.addend <= (pend.addend & ~go.addend) | req.addend;
        end
    end

    a_r6_init_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.init && !req.init) |=> !pend.init);

    a_r7_addend_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.addend && !req.addend) |=> !pend.addend);

    a_r10_update_waits_for_init: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.init && pend.update) |=> pend.update);

endmodule

// File: rtl/ptp_tc_rate.sv
// ptp_tc_rate: decides on which edges the sub-second step is applied.
// In coarse mode it fires every cycle. In fine mode it fires on the carry
// out of an accumulator that adds the active addend every cycle.
// Assumes: the accumulator holds its value while coarse mode is selected.
module ptp_tc_rate #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fine,
    input  logic [ACC_W-1:0] addend_stage,
    input  logic             load_addend,
    output logic             tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] addend_q;
    logic [ACC_W:0]   acc_sum;

    localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

    // Accumulator sum with carry, and the step enable.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, addend_q};
        tick    = fine ? acc_sum[ACC_W] : 1'b1;
    end

    // Accumulator register: advances only in fine mode.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (fine)  acc_q <= acc_sum[ACC_W-1:0];
    end

    // Active addend: copied from the staged value on command.
    always_ff @(posedge clk) begin
        if (!rst_n)           addend_q <= '0;
        else if (load_addend) addend_q <= addend_stage;
    end

    a_r7_addend_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        load_addend |=> (addend_q == $past(addend_stage)));

    a_r3_half_addend_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (fine && $past(fine) && $past(tick) && addend_q == HALF && $past(addend_q) == HALF)
        |-> !tick);

endmodule

// File: rtl/ptp_tc_time.sv
// ptp_tc_time: the seconds and sub-second registers.
// Priority per edge: init load, then offset update, then the sub-second step.
// Offsets and steps wrap the sub-second word at the active limit and carry
// or borrow into seconds.
// Assumes: DIG_LIMIT <= 2**SUB_W, and software supplies sub-second values
// below the active limit.
module ptp_tc_time #(
    parameter int SEC_W     = 32,
    parameter int SUB_W     = 31,
    parameter int INC_W     = 8,
    parameter int DIG_LIMIT = 1_000_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             digital,
    input  logic             tick,
    input  logic [INC_W-1:0] inc,
    input  logic             go_init,
    input  logic             go_update,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [SUB_W-1:0] upd_sub,
    input  logic             upd_neg,
    output logic [SEC_W-1:0] sec_q,
    output logic [SUB_W-1:0] sub_q
);

    localparam int LIM_W = SUB_W + 1;
    localparam logic [LIM_W-1:0] BIN_LIM = {1'b1, {SUB_W{1'b0}}};
    localparam logic [LIM_W-1:0] DIG_LIM = LIM_W'(DIG_LIMIT);

    logic [LIM_W-1:0] lim;
    logic [LIM_W-1:0] off_sum;
    logic [LIM_W-1:0] stp_sum;
    logic             off_ovf;
    logic             stp_ovf;
    logic [SUB_W-1:0] off_sub;
    logic [SUB_W-1:0] stp_sub;
    logic [SEC_W-1:0] off_sec;

    // Active limit, and the wrapped results of an offset and of a step.
    always_comb begin
        lim     = digital ? DIG_LIM : BIN_LIM;
        off_sum = {1'b0, sub_q} + {1'b0, upd_sub};
        off_ovf = (off_sum >= lim);
        off_sub = off_ovf ? SUB_W'(off_sum - lim) : off_sum[SUB_W-1:0];
        off_sec = sec_q + upd_sec + SEC_W'(off_ovf) - SEC_W'(upd_neg);
        stp_sum = {1'b0, sub_q} + LIM_W'(inc);
        stp_ovf = (stp_sum >= lim);
        stp_sub = stp_ovf ? SUB_W'(stp_sum - lim) : stp_sum[SUB_W-1:0];
    end

    // Time registers: load, offset or step, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            sub_q <= '0;
        end else if (go_init) begin
            sec_q <= upd_sec;
            sub_q <= upd_sub;
        end else if (go_update) begin
            sec_q <= off_sec;
            sub_q <= off_sub;
        end else if (tick) begin
            sec_q <= sec_q + SEC_W'(stp_ovf);
            sub_q <= stp_sub;
        end
    end

    a_r6_init_loads_time: assert property (@(posedge clk) disable iff (!rst_n)
        go_init |=> (sec_q == $past(upd_sec) && sub_q == $past(upd_sub)));

    a_r9_sub_stays_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(digital) && ({1'b0, $past(sub_q)} < $past(lim)) && !$past(go_init)
         && !($past(go_update) && ({1'b0, $past(upd_sub)} >= $past(lim))))
        |-> ({1'b0, sub_q} < lim));

    a_r11_no_step_on_command: assert property (@(posedge clk) disable iff (!rst_n)
        (go_update && upd_sub == '0 && upd_sec == '0 && !upd_neg)
        |=> (sub_q == $past(sub_q) && sec_q == $past(sec_q)));

endmodule

// File: rtl/ptp_tc_snap.sv
// ptp_tc_snap: freezes both time words together on a read request so that
// software can read the pair without tearing.
// Assumes: the request is synchronous to clk.
module ptp_tc_snap #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [SEC_W-1:0] sec_in,
    input  logic [SUB_W-1:0] sub_in,
    output logic [SEC_W-1:0] sec_out,
    output logic [SUB_W-1:0] sub_out
);

    // Snapshot registers: both words captured at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_out <= '0;
            sub_out <= '0;
        end else if (capture) begin
            sec_out <= sec_in;
            sub_out <= sub_in;
        end
    end

    a_r12_coherent_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (sec_out == $past(sec_in) && sub_out == $past(sub_in)));

    a_r12_holds_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(sec_out) && $stable(sub_out)));

endmodule

// File: rtl/ptp_time_counter.sv
// ptp_time_counter: top level of the time-of-day counter.
// Connects the command sequencer, the rate generator, the time registers
// and the snapshot stage.
// Assumes: all inputs are synchronous to clk. Bit SUB_W of upd_subsec is
// the subtract flag.
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int SEC_W     = 32,
    parameter int SUB_W     = 31,
    parameter int INC_W     = 8,
    parameter int ACC_W     = 32,
    parameter int DIG_LIMIT = 1_000_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fine_mode,
    input  logic             digital_mode,
    input  logic [INC_W-1:0] sub_inc,
    input  logic [ACC_W-1:0] addend_stage,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [SUB_W:0]   upd_subsec,
    input  logic             cmd_init,
    input  logic             cmd_update,
    input  logic             cmd_addend,
    input  logic             snap_req,
    output logic             busy_init,
    output logic             busy_update,
    output logic             busy_addend,
    output logic [SEC_W-1:0] time_sec,
    output logic [SUB_W-1:0] time_subsec,
    output logic [SEC_W-1:0] snap_sec,
    output logic [SUB_W-1:0] snap_subsec
);

    ptp_cmd_t req;
    ptp_cmd_t pend;
    ptp_cmd_t go;
    logic     tick;

    // Gather the command requests and expose the pending flags.
    always_comb begin
        req.init    = cmd_init;
        req.update  = cmd_update;
        req.addend  = cmd_addend;
        busy_init   = pend.init;
        busy_update = pend.update;
        busy_addend = pend.addend;
    end

    ptp_tc_cmd u_cmd (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req),
        .pend (pend),
        .go   (go)
    );

    ptp_tc_rate #(.ACC_W(ACC_W)) u_rate (
        .clk         (clk),
        .rst_n       (rst_n),
        .fine        (fine_mode),
        .addend_stage(addend_stage),
        .load_addend (go.addend),
        .tick        (tick)
    );

    ptp_tc_time #(
        .SEC_W    (SEC_W),
        .SUB_W    (SUB_W),
        .INC_W    (INC_W),
        .DIG_LIMIT(DIG_LIMIT)
    ) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .digital  (digital_mode),
        .tick     (tick),
        .inc      (sub_inc),
        .go_init  (go.init),
        .go_update(go.update),
        .upd_sec  (upd_sec),
        .upd_sub  (upd_subsec[SUB_W-1:0]),
        .upd_neg  (upd_subsec[SUB_W]),
        .sec_q    (time_sec),
        .sub_q    (time_subsec)
    );

    ptp_tc_snap #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(snap_req),
        .sec_in (time_sec),
        .sub_in (time_subsec),
        .sec_out(snap_sec),
        .sub_out(snap_subsec)
    );

endmodule

// File: tb/ptp_time_counter_tb.sv
// Scoreboard bench: the driver pushes expected items, the monitor compares them.
module ptp_time_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fine_mode = 1'b0;
    logic        digital_mode = 1'b1;
    logic [7:0]  sub_inc = '0;
    logic [31:0] addend_stage = '0;
    logic [31:0] upd_sec = '0;
    logic [31:0] upd_subsec = '0;
    logic        cmd_init = 1'b0;
    logic        cmd_update = 1'b0;
    logic        cmd_addend = 1'b0;
    logic        snap_req = 1'b0;
    logic        busy_init, busy_update, busy_addend;
    logic [31:0] time_sec, snap_sec;
    logic [30:0] time_subsec, snap_subsec;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] a;
        logic [31:0] b;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    ptp_time_counter dut_i (
        .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode), .digital_mode(digital_mode),
        .sub_inc(sub_inc), .addend_stage(addend_stage), .upd_sec(upd_sec),
        .upd_subsec(upd_subsec), .cmd_init(cmd_init), .cmd_update(cmd_update),
        .cmd_addend(cmd_addend), .snap_req(snap_req), .busy_init(busy_init),
        .busy_update(busy_update), .busy_addend(busy_addend), .time_sec(time_sec),
        .time_subsec(time_subsec), .snap_sec(snap_sec), .snap_subsec(snap_subsec)
    );

    // Item kinds: 0 live time, 1 snapshot, 2 busy flags {init,update,addend}.
    task automatic push(string tag, int kind, logic [31:0] a, logic [31:0] b);
        item_t it;
        it.tag = tag; it.kind = kind; it.a = a; it.b = b;
        sb_q.push_back(it);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_init(logic [31:0] s, logic [30:0] n);
        @(negedge clk);
        upd_sec = s; upd_subsec = {1'b0, n}; cmd_init = 1'b1;
        edges(1);
        @(negedge clk);
        cmd_init = 1'b0;
        edges(1);
    endtask

    task automatic do_update(string tag, logic [31:0] s, logic [30:0] n, logic neg);
        @(negedge clk);
        upd_sec = s; upd_subsec = {neg, n}; cmd_update = 1'b1;
        edges(1);
        push(tag, 2, 32'd2, 0);
        @(negedge clk);
        cmd_update = 1'b0;
        edges(1);
    endtask

    // Monitor: compares every queued item against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] ga, gb;
                it = sb_q.pop_front();
                case (it.kind)
                    0: begin ga = time_sec; gb = {1'b0, time_subsec}; end
                    1: begin ga = snap_sec; gb = {1'b0, snap_subsec}; end
                    default: begin ga = {29'd0, busy_init, busy_update, busy_addend}; gb = 0; end
                endcase
                tests++;
                if (ga !== it.a || gb !== it.b) begin
                    fails++;
                    $display("FAIL %s: actual %0d/%0d expected %0d/%0d", it.tag, ga, gb, it.a, it.b);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Driver.
    initial begin
        edges(3);
        @(negedge clk); rst_n = 1'b1;
        edges(1);
        push("R1 time", 0, 0, 0); push("R1 snap", 1, 0, 0); push("R1 busy", 2, 0, 0);

        // R6 init load.
        @(negedge clk); upd_sec = 5; upd_subsec = 100; cmd_init = 1'b1;
        edges(1); push("R6 busy set", 2, 32'd4, 0);
        @(negedge clk); cmd_init = 1'b0;
        edges(1); push("R6 loaded", 0, 5, 100); push("R6 busy clear", 2, 0, 0);

        // R2 coarse stepping.
        @(negedge clk); sub_inc = 10;
        edges(3); push("R2 coarse", 0, 5, 130);

        // R11 no step on the load edge.
        @(negedge clk); upd_sec = 7; upd_subsec = 0; cmd_init = 1'b1;
        edges(1); push("R11 pre", 0, 5, 140);
        @(negedge clk); cmd_init = 1'b0;
        edges(1); push("R11 load edge", 0, 7, 0);
        edges(1); push("R11 resume", 0, 7, 10);

        // R4 digital wrap.
        do_init(9, 31'd999_999_995);
        edges(1); push("R4 digital wrap", 0, 10, 5);

        // R5 binary wrap.
        @(negedge clk); digital_mode = 1'b0;
        do_init(3, 31'h7FFF_FFFC);
        edges(1); push("R5 binary wrap", 0, 4, 6);

        // R8 add offset with carry.
        @(negedge clk); digital_mode = 1'b1; sub_inc = 0;
        do_init(100, 31'd999_999_000);
        do_update("R8 busy", 2, 31'd1500, 1'b0);
        push("R8 add carry", 0, 103, 500);

        // R9 subtract 1 s 700 ns with borrow, digital.
        do_update("R9 busy", 32'hFFFF_FFFF, 31'd999_999_300, 1'b1);
        push("R9 sub borrow", 0, 101, 999_999_800);

        // R9 subtract 200 counts, binary, no borrow.
        @(negedge clk); digital_mode = 1'b0;
        do_init(50, 31'd1000);
        do_update("R9 busy bin", 0, 31'h7FFF_FF38, 1'b1);
        push("R9 sub binary", 0, 50, 800);

        // R10 init and update together.
        @(negedge clk); digital_mode = 1'b1; upd_sec = 20; upd_subsec = 100;
        cmd_init = 1'b1; cmd_update = 1'b1;
        edges(1); push("R10 both pending", 2, 32'd6, 0);
        @(negedge clk); cmd_init = 1'b0; cmd_update = 1'b0;
        edges(1); push("R10 init first", 0, 20, 100); push("R10 update waits", 2, 32'd2, 0);
        edges(1); push("R10 update next", 0, 40, 200); push("R10 idle", 2, 0, 0);

        // R3 and R7 fine mode.
        @(negedge clk); fine_mode = 1'b1; sub_inc = 20;
        do_init(1, 0);
        edges(3); push("R3 zero addend", 0, 1, 0);
        @(negedge clk); addend_stage = 32'h8000_0000; cmd_addend = 1'b1;
        edges(1); push("R7 busy", 2, 32'd1, 0);
        @(negedge clk); cmd_addend = 1'b0;
        edges(1); push("R7 busy clear", 2, 0, 0); push("R7 load edge", 0, 1, 0);
        edges(1); push("R3 no carry", 0, 1, 0);
        edges(1); push("R3 carry", 0, 1, 20);
        edges(2); push("R3 half rate", 0, 1, 40);

        // R12 snapshot.
        @(negedge clk); fine_mode = 1'b0; sub_inc = 10;
        do_init(77, 500);
        @(negedge clk); snap_req = 1'b1;
        edges(1); push("R12 snap", 1, 77, 500); push("R12 live", 0, 77, 510);
        @(negedge clk); snap_req = 1'b0;
        edges(2); push("R12 snap held", 1, 77, 500); push("R12 live on", 0, 77, 530);

        @(negedge clk); #1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule